// File: doc/BRIEF.md
# DVFS Operating-Point Transition Sequencer

This block moves a synchronous clock domain from its present voltage/frequency operating point to a requested one. It drives a voltage set-point (a level index) to a separate supply actuator and a frequency set-point (an oscillator code) to a separate clock actuator. It changes only one of them at a time. The next step waits until the actuator that was just commanded reports that it has settled. The order of the steps depends on the direction of the move. A frequency decrease is always applied first. A voltage change comes next. A frequency increase comes last. With this order the applied pair never goes past the per-level frequency limit held in a table that the caller supplies.

A request is taken only while the block is idle. The request is first clamped to a fixed voltage ceiling, and then to the table limit for the clamped level. The sequencer runs through named states:
- `ST_IDLE` accepts a request.
- `ST_F_LOWER` applies a frequency decrease.
- `ST_V_MOVE` applies the voltage change.
- `ST_F_RAISE` applies a frequency increase.
- `ST_FINISH` pulses done.

The transitions out of `ST_IDLE` are accept-to-lower, accept-to-move, accept-to-raise and accept-to-finish when nothing changes. The transitions out of a wait state are settle-to-next-step, settle-to-finish and timeout-to-idle. The finish state always returns to idle.

A watchdog counts the cycles spent in each wait state. If a settle indication does not arrive within a programmable number of cycles, the watchdog raises a sticky error flag and abandons the move. The error flag clears when the next request is accepted.

Top module: `dvfs_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes to idle with `v_set`=0, `f_set`=0, and `busy`, `done` and `err` all 0.
- R2: When both voltage and frequency rise, `v_set` changes first while `f_set` is held. `f_set` changes only in the cycle after `v_settled` is sampled high in the voltage step.
- R3: When both voltage and frequency fall, `f_set` changes first. `v_set` changes only in the cycle after `f_settled` is sampled high in the frequency step.
- R4: The requested frequency code is clamped to entry `fmax_tbl[8*v+7 -: 8]` for the clamped target level v. At every cycle the applied `f_set` is no greater than the entry for the applied `v_set`.
- R5: A requested voltage index above the ceiling parameter `VCEIL` (default 6) is clamped to `VCEIL`, and `v_set` never exceeds `VCEIL`.
- R6: When only one of voltage or frequency differs from the applied point, only that set-point changes. A request equal to the applied point produces the done pulse in the cycle after acceptance and no set-point change.
- R7: `req_valid` is ignored while `busy` is high. Neither the set-points nor the sequence react to it.
- R8: `done` is high for exactly one cycle. It rises in the cycle after the final settle indication is sampled, and `busy` falls in the following cycle.
- R9: If the awaited settle input stays low while the wait-state counter runs from 0 up to `wd_limit`, then `err` rises, the block returns to idle, no done pulse is produced and the set-points stay as they are. `err` clears when the next request is accepted.
- R10: A move that raises voltage and lowers frequency lowers `f_set` first, and changes `v_set` only after `f_settled`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled only when idle |
| req_vidx | input | 3 | Requested voltage level index |
| req_fcode | input | 8 | Requested frequency code |
| fmax_tbl | input | 64 | Packed table of eight 8-bit maximum frequency codes, entry i at bits 8i+7..8i |
| v_settled | input | 1 | Voltage actuator settled indication |
| f_settled | input | 1 | Frequency actuator settled indication |
| wd_limit | input | 16 | Watchdog limit in cycles per wait state |
| v_set | output | 3 | Applied voltage set-point |
| f_set | output | 8 | Applied frequency set-point |
| busy | output | 1 | A transition is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky watchdog timeout flag |

## Verification
A request sampled at edge k changes the first set-point, or raises `done` when nothing moves, in the cycle right after k. Each settle pulse sampled at edge m makes the next set-point change, or `done`, visible right after m. `done` falls and `busy` clears one edge later. A timeout raises `err` on the edge where the wait counter has reached `wd_limit` with no settle seen.

The bench drives inputs and the actuator responses on the falling edge. For every request it predicts the ordered list of output changes and queues it. A monitor looks at the outputs on each falling edge, and every time a change appears it compares that change against the next queued item. In this way the order of the steps and the absence of any extra step are both checked, and these checks do not depend on the latency the actuators are given.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_F_LOWER = 3'd1,
        ST_V_MOVE  = 3'd2,
        ST_F_RAISE = 3'd3,
        ST_FINISH  = 3'd4
    } seq_state_t;
endpackage

// File: rtl/dvfs_target_clamp.sv
module dvfs_target_clamp #(
    parameter int VW    = 3,
    parameter int FW    = 8,
    parameter int VCEIL = 6
) (
    input  logic [VW-1:0]          req_vidx,
    input  logic [FW-1:0]          req_fcode,
    input  logic [(1<<VW)*FW-1:0]  fmax_tbl,
    output logic [VW-1:0]          tgt_vidx,
    output logic [FW-1:0]          tgt_fcode
);
    localparam int NLVL = 1 << VW;
    localparam logic [VW-1:0] CEIL_IDX = VW'(VCEIL);

    logic [FW-1:0] lim [NLVL];

    for (genvar gi = 0; gi < NLVL; gi++) begin : g_unpack
        assign lim[gi] = fmax_tbl[gi*FW +: FW];
    end

    always_comb begin
        tgt_vidx  = (req_vidx > CEIL_IDX) ? CEIL_IDX : req_vidx;
        tgt_fcode = (req_fcode > lim[tgt_vidx]) ? lim[tgt_vidx] : req_fcode;
    end
endmodule

// File: rtl/dvfs_wdog.sv
module dvfs_wdog #(
    parameter int WDW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart,
    input  logic           run,
    input  logic [WDW-1:0] limit,
    output logic           expired
);
    logic [WDW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (run && cnt != limit) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == limit);
endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq
    import dvfs_pkg::*;
#(
    parameter int VW    = 3,
    parameter int FW    = 8,
    parameter int WDW   = 16,
    parameter int VCEIL = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [VW-1:0]          req_vidx,
    input  logic [FW-1:0]          req_fcode,
    input  logic [(1<<VW)*FW-1:0]  fmax_tbl,
    input  logic                   v_settled,
    input  logic                   f_settled,
    input  logic [WDW-1:0]         wd_limit,
    output logic [VW-1:0]          v_set,
    output logic [FW-1:0]          f_set,
    output logic                   busy,
    output logic                   done,
    output logic                   err
);
    localparam logic [VW-1:0] CEIL_IDX = VW'(VCEIL);

    seq_state_t state, nxt;
    logic [VW-1:0] clamp_v, tgt_v, cand_v;
    logic [FW-1:0] clamp_f, tgt_f, cand_f;
    logic          waiting, expired, timeout_evt;

    dvfs_target_clamp #(.VW(VW), .FW(FW), .VCEIL(VCEIL)) u_clamp (
        .req_vidx  (req_vidx),
        .req_fcode (req_fcode),
        .fmax_tbl  (fmax_tbl),
        .tgt_vidx  (clamp_v),
        .tgt_fcode (clamp_f)
    );

    assign waiting = (state == ST_F_LOWER) || (state == ST_V_MOVE) || (state == ST_F_RAISE);

    dvfs_wdog #(.WDW(WDW)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (nxt != state),
        .run     (waiting),
        .limit   (wd_limit),
        .expired (expired)
    );

    assign cand_v = (state == ST_IDLE) ? clamp_v : tgt_v;
    assign cand_f = (state == ST_IDLE) ? clamp_f : tgt_f;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (cand_f < f_set)       nxt = ST_F_LOWER;
                    else if (cand_v != v_set) nxt = ST_V_MOVE;
                    else if (cand_f > f_set)  nxt = ST_F_RAISE;
                    else                      nxt = ST_FINISH;
                end
            end
            ST_F_LOWER: begin
                if (f_settled)    nxt = (tgt_v != v_set) ? ST_V_MOVE : ST_FINISH;
                else if (expired) nxt = ST_IDLE;
            end
            ST_V_MOVE: begin
                if (v_settled)    nxt = (tgt_f > f_set) ? ST_F_RAISE : ST_FINISH;
                else if (expired) nxt = ST_IDLE;
            end
            ST_F_RAISE: begin
                if (f_settled)    nxt = ST_FINISH;
                else if (expired) nxt = ST_IDLE;
            end
            ST_FINISH: nxt = ST_IDLE;
        endcase
    end

    assign timeout_evt = waiting && (nxt == ST_IDLE);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Output and target registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_set <= '0;
            f_set <= '0;
            tgt_v <= '0;
            tgt_f <= '0;
            err   <= 1'b0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                tgt_v <= clamp_v;
                tgt_f <= clamp_f;
                err   <= 1'b0;
            end
            if (nxt != state) begin
                unique case (nxt)
                    ST_F_LOWER, ST_F_RAISE: f_set <= cand_f;
                    ST_V_MOVE:              v_set <= cand_v;
                    default: ;
                endcase
            end
            if (timeout_evt) err <= 1'b1;
        end
    end

    assign busy = (state != ST_IDLE);
    assign done = (state == ST_FINISH);

    // R4
    safe_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_set <= fmax_tbl[v_set*FW +: FW]);
    // R5
    ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_set <= CEIL_IDX);
    // R2
    one_actuator_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((v_set != $past(v_set)) && (f_set != $past(f_set))));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    // R9
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !busy);
    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(tgt_v) && $stable(tgt_f)));
endmodule

// File: tb/dvfs_seq_bench.sv
module dvfs_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_vidx = '0;
    logic [7:0]  req_fcode = '0;
    logic [63:0] fmax_tbl;
    logic        v_settled = 1'b0;
    logic        f_settled = 1'b0;
    logic [15:0] wd_limit = 16'd20;
    logic [2:0]  v_set;
    logic [7:0]  f_set;
    logic        busy, done, err;

    always #2 clk = ~clk;

    dvfs_seq u_dvfs_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vidx(req_vidx),
        .req_fcode(req_fcode), .fmax_tbl(fmax_tbl), .v_settled(v_settled),
        .f_settled(f_settled), .wd_limit(wd_limit), .v_set(v_set), .f_set(f_set),
        .busy(busy), .done(done), .err(err)
    );

    typedef struct {
        logic [2:0] v;
        logic [7:0] f;
        logic       d;
        logic       e;
        int         tag;
    } exp_t;

    exp_t       q[$];
    int         n_chk = 0;
    int         n_bad = 0;
    logic [7:0] tbl [8];
    bit         v_mute = 0, f_mute = 0, mon_en = 0;
    int         v_lat = 2, f_lat = 3;
    logic [2:0] mv = 0;
    logic [7:0] mf = 0;

    initial begin
        for (int i = 0; i < 8; i++) begin
            tbl[i] = 8'(40 + 30*i);
            fmax_tbl[i*8 +: 8] = 8'(40 + 30*i);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic push(input logic [2:0] v, input logic [7:0] f,
                        input logic d, input logic e, input int tag);
        exp_t x;
        x.v = v; x.f = f; x.d = d; x.e = e; x.tag = tag;
        q.push_back(x);
    endtask

    // Monitor: compares every observed output change with the next expected item
    initial begin
        logic [12:0] prev, cur;
        prev = '0;
        forever begin
            @(negedge clk);
            cur = {err, done, f_set, v_set};
            if (mon_en && cur != prev) begin
                if (q.size() == 0) begin
                    check(0, "R7", "unexpected output change", int'(cur), int'(prev));
                end else begin
                    exp_t x;
                    x = q.pop_front();
                    check(cur == {x.e, x.d, x.f, x.v}, $sformatf("R%0d", x.tag),
                          "output step", int'(cur), int'({x.e, x.d, x.f, x.v}));
                end
                check(f_set <= tbl[v_set], "R4", "applied pair safe", f_set, tbl[v_set]);
                check(v_set <= 3'd6, "R5", "ceiling", v_set, 6);
            end
            prev = cur;
        end
    end

    // Voltage actuator model
    initial begin
        logic [2:0] last;
        int cnt;
        bit pend;
        last = 0; cnt = 0; pend = 0;
        forever begin
            @(negedge clk);
            v_settled = 1'b0;
            if (v_set != last) begin
                last = v_set; cnt = v_lat; pend = !v_mute;
            end else if (pend) begin
                if (cnt == 0) begin v_settled = 1'b1; pend = 0; end
                else cnt--;
            end
        end
    end

    // Frequency actuator model
    initial begin
        logic [7:0] last;
        int cnt;
        bit pend;
        last = 0; cnt = 0; pend = 0;
        forever begin
            @(negedge clk);
            f_settled = 1'b0;
            if (f_set != last) begin
                last = f_set; cnt = f_lat; pend = !f_mute;
            end else if (pend) begin
                if (cnt == 0) begin f_settled = 1'b1; pend = 0; end
                else cnt--;
            end
        end
    end

    // Driver: predicts the ordered output changes, then issues the request
    task automatic run_txn(input logic [2:0] rv, input logic [7:0] rf, input int tag,
                           input bit intrude, input int stall);
        logic [2:0] tv;
        logic [7:0] tf;
        bit stop;
        tv = (rv > 3'd6) ? 3'd6 : rv;
        tf = (rf > tbl[tv]) ? tbl[tv] : rf;
        stop = 0;
        v_mute = (stall == 1);
        f_mute = (stall == 2);
        if (tf < mf) begin
            mf = tf; push(mv, mf, 0, 0, tag);
            if (stall == 2) begin push(mv, mf, 0, 1, 9); stop = 1; end
        end
        if (!stop && tv != mv) begin
            mv = tv; push(mv, mf, 0, 0, tag);
            if (stall == 1) begin push(mv, mf, 0, 1, 9); stop = 1; end
        end
        if (!stop && tf > mf) begin
            mf = tf; push(mv, mf, 0, 0, tag);
            if (stall == 2) begin push(mv, mf, 0, 1, 9); stop = 1; end
        end
        if (!stop) begin
            push(mv, mf, 1, 0, 8);
            push(mv, mf, 0, 0, 8);
        end
        @(negedge clk);
        req_vidx = rv; req_fcode = rf; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (intrude) begin
            @(negedge clk);
            check(busy == 1'b1, "R7", "busy during move", busy, 1);
            req_vidx = 3'd6; req_fcode = 8'd250; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        for (int k = 0; k < 500 && busy; k++) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check(q.size() == 0, $sformatf("R%0d", tag), "all steps seen", q.size(), 0);
        check(busy == 1'b0, "R8", "busy cleared", busy, 0);
        q.delete();
        v_mute = 0; f_mute = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(v_set == 0 && f_set == 0, "R1", "reset set-points", {v_set, f_set}, 0);
        check(!busy && !done && !err, "R1", "reset flags", {busy, done, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_en = 1;
        run_txn(3'd4, 8'd150, 2, 0, 0);   // R2: raise both
        run_txn(3'd2, 8'd60, 3, 1, 0);    // R3 lower both, R7 intrusion ignored
        run_txn(3'd7, 8'd255, 5, 0, 0);   // R5 ceiling, R4 clamp
        run_txn(3'd3, 8'd120, 3, 0, 0);   // R3 lower both
        run_txn(3'd5, 8'd50, 10, 0, 0);   // R10 voltage up, frequency down
        run_txn(3'd6, 8'd50, 6, 0, 0);    // R6 voltage only
        run_txn(3'd6, 8'd200, 6, 0, 0);   // R6 frequency only
        run_txn(3'd6, 8'd200, 6, 0, 0);   // R6 no change
        run_txn(3'd2, 8'd255, 4, 0, 0);   // R4 frequency clamp to level limit
        run_txn(3'd2, 8'd30, 9, 0, 2);    // R9 frequency actuator timeout
        check(err == 1'b1, "R9", "err after timeout", err, 1);
        run_txn(3'd2, 8'd30, 9, 0, 0);    // R9 err cleared on next accept
        check(err == 1'b0, "R9", "err cleared", err, 0);
        run_txn(3'd4, 8'd30, 9, 0, 1);    // R9 voltage actuator timeout
        v_lat = 0; f_lat = 5;
        run_txn(3'd0, 8'd0, 3, 0, 0);     // R3 with other latencies
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired (all requirements): actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule